// File: doc/BRIEF.md
# Page Request Ring Queue

This block is the hardware producer of a circular queue of page-request descriptors. Each incoming request is a 256-bit descriptor, which occupies 32 bytes in the ring. When the queue is enabled and has room, the block stores the descriptor in its ring memory at the current tail. It then moves the tail forward by one descriptor, wrapping at the end of the ring. Head and tail are byte offsets, masked to the ring size `DEPTH*32` and always aligned to 32 bytes.

Software watches the queue through a small register port. The port holds the head offset, the tail offset, a status word and a control word. Software reads descriptors through a separate entry read port. It walks from head to tail, and it then releases the entries by writing the tail value into head.

The status word has two write-1-to-clear flags:
- a pending flag, raised by every stored descriptor;
- an overflow flag, raised when a request finds the ring full.

The overflow flag blocks all further requests, and it can be cleared only once the ring is empty. An interrupt request line follows the pending flag when interrupts are enabled.

Top module: `prq_ring_queue`

## Requirements
- R1: After reset, head, tail, status and control all read zero, and irqReq is low.
- R2: An accepted descriptor is stored at entry index tail/32, readable on rdEntryData when rdEntryIdx selects that entry. The tail then becomes (tail+32) mod (DEPTH*32) one cycle later.
- R3: While control bit 0 (queue enable) is 0, requests are ignored: tail, status and the stored entries are unchanged.
- R4: Status bit 0 (pending) is set by each accepted descriptor and cleared by writing 1 to it. When an acceptance and a clear happen in the same cycle, the flag stays set.
- R5: The ring is full when (tail+32) mod (DEPTH*32) equals head. A request that arrives while the ring is full is dropped, tail is unchanged, and status bit 1 (overflow) is set.
- R6: While the overflow flag is set, every request is dropped and tail is unchanged, even when the ring has room.
- R7: Writing 1 to status bit 1 clears the overflow flag only when head equals tail. If the ring is not empty, the write has no effect.
- R8: A write to head (or tail) keeps only the offset bits below log2(DEPTH*32) and forces the low 5 bits to zero. Writing the tail value into head empties the ring.
- R9: irqReq is high exactly while the pending flag is set and control bit 1 (interrupt enable) is 1.
- R10: The register map is: regAddr 0 is head, 1 is tail, 2 is status, 3 is control. regRdData shows the register selected by regAddr within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request descriptor is present this cycle |
| reqData | input | 256 | Request descriptor |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Selected register value |
| rdEntryIdx | input | log2(DEPTH) | Ring entry to read |
| rdEntryData | output | 256 | Stored descriptor at rdEntryIdx |
| irqReq | output | 1 | Interrupt request |

## Verification
The bench fills a four-entry ring until it wraps and becomes full, which exposes a tail that forgets to wrap or a full test that is one entry off. A design with that fault would either overwrite unread entries or report overflow too early. The bench also tries to clear overflow while entries remain, and sends requests while overflow is set although the ring has room. A design that got these wrong would drop the flag early or store descriptors that software would treat as missing. Finally, a pending clear that lands in the same cycle as an arrival must not lose the new notification, and a head write with stray low bits must come back aligned.

// File: rtl/prq_pkg.sv
package prq_pkg;
  localparam int DescBytes = 32;
  localparam int DescShift = 5;
  localparam int DescW     = 256;
  localparam int RegW      = 32;

  typedef enum logic [1:0] {
    SelHead   = 2'd0,
    SelTail   = 2'd1,
    SelStatus = 2'd2,
    SelCtrl   = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic headWr;
    logic tailWr;
  } ringStrobe_t;
endpackage

// File: rtl/prq_data.sv
module prq_data
  import prq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int OffW = $clog2(DEPTH * DescBytes),
  localparam int IdxW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobe_t       strb,
  input  logic [OffW-1:0]   wrOffset,
  input  logic [DescW-1:0]  reqData,
  input  logic [IdxW-1:0]   rdEntryIdx,
  output logic [DescW-1:0]  rdEntryData,
  output logic [OffW-1:0]   headOff,
  output logic [OffW-1:0]   tailOff,
  output logic              ringFull,
  output logic              ringEmpty
);
  localparam logic [OffW-1:0] Step = OffW'(DescBytes);

  logic [DescW-1:0] ringMem [DEPTH];
  logic [OffW-1:0]  nextTail;
  logic [OffW-1:0]  alignedWr;
  logic [IdxW-1:0]  wrIdx;

  assign nextTail  = tailOff + Step;
  assign alignedWr = {wrOffset[OffW-1:DescShift], {DescShift{1'b0}}};
  assign wrIdx     = tailOff[OffW-1:DescShift];
  assign ringFull  = (nextTail == headOff);
  assign ringEmpty = (headOff == tailOff);

  always_ff @(posedge clk) begin
    if (strb.push) ringMem[wrIdx] <= reqData;
  end

  assign rdEntryData = ringMem[rdEntryIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headOff <= '0;
      tailOff <= '0;
    end else begin
      if (strb.headWr) headOff <= alignedWr;
      if (strb.tailWr) tailOff <= alignedWr;
      else if (strb.push) tailOff <= nextTail;
    end
  end
endmodule

// File: rtl/prq_ctrl.sv
module prq_ctrl
  import prq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int OffW = $clog2(DEPTH * DescBytes)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [RegW-1:0]  regWrData,
  input  logic [OffW-1:0]  headOff,
  input  logic [OffW-1:0]  tailOff,
  input  logic             ringFull,
  input  logic             ringEmpty,
  output ringStrobe_t      strb,
  output logic [OffW-1:0]  wrOffset,
  output logic [RegW-1:0]  regRdData,
  output logic             irqReq,
  output logic             pendingQ,
  output logic             overflowQ,
  output logic             queueEn
);
  logic    [1:0] ctrlQ;
  regSel_e       sel;
  logic          wrStatus;
  logic          accept;
  logic          dropFull;

  assign sel      = regSel_e'(regAddr);
  assign wrStatus = regWrEn && (sel == SelStatus);
  assign queueEn  = ctrlQ[0];
  assign accept   = reqValid && queueEn && !overflowQ && !ringFull;
  assign dropFull = reqValid && queueEn && !overflowQ && ringFull;

  always_comb begin
    strb.push   = accept;
    strb.headWr = regWrEn && (sel == SelHead);
    strb.tailWr = regWrEn && (sel == SelTail);
  end
  assign wrOffset = regWrData[OffW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ     <= '0;
      pendingQ  <= 1'b0;
      overflowQ <= 1'b0;
    end else begin
      if (regWrEn && sel == SelCtrl) ctrlQ <= regWrData[1:0];
      if (accept) pendingQ <= 1'b1;
      else if (wrStatus && regWrData[0]) pendingQ <= 1'b0;
      if (dropFull) overflowQ <= 1'b1;
      else if (wrStatus && regWrData[1] && ringEmpty) overflowQ <= 1'b0;
    end
  end

  always_comb begin
    unique case (sel)
      SelHead:   regRdData = RegW'(headOff);
      SelTail:   regRdData = RegW'(tailOff);
      SelStatus: regRdData = RegW'({overflowQ, pendingQ});
      default:   regRdData = RegW'(ctrlQ);
    endcase
  end

  assign irqReq = pendingQ && ctrlQ[1];
endmodule

// File: rtl/prq_ring_queue.sv
module prq_ring_queue
  import prq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int OffW = $clog2(DEPTH * DescBytes),
  localparam int IdxW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [DescW-1:0] reqData,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [RegW-1:0]  regWrData,
  output logic [RegW-1:0]  regRdData,
  input  logic [IdxW-1:0]  rdEntryIdx,
  output logic [DescW-1:0] rdEntryData,
  output logic             irqReq
);
  ringStrobe_t     strb;
  logic [OffW-1:0] wrOffset;
  logic [OffW-1:0] headOff;
  logic [OffW-1:0] tailOff;
  logic            ringFull;
  logic            ringEmpty;
  logic            pendingQ;
  logic            overflowQ;
  logic            queueEn;
  logic            pushStrobe;
  logic            tailWrStrobe;

  assign pushStrobe   = strb.push;
  assign tailWrStrobe = strb.tailWr;

  prq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .headOff(headOff),
    .tailOff(tailOff), .ringFull(ringFull), .ringEmpty(ringEmpty),
    .strb(strb), .wrOffset(wrOffset), .regRdData(regRdData),
    .irqReq(irqReq), .pendingQ(pendingQ), .overflowQ(overflowQ),
    .queueEn(queueEn)
  );

  prq_data #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrOffset(wrOffset),
    .reqData(reqData), .rdEntryIdx(rdEntryIdx), .rdEntryData(rdEntryData),
    .headOff(headOff), .tailOff(tailOff), .ringFull(ringFull),
    .ringEmpty(ringEmpty)
  );
endmodule

// File: rtl/prq_checker.sv
module prq_checker #(
  parameter int OffW = 11
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            queueEn,
  input logic            ringFull,
  input logic            ringEmpty,
  input logic            pushStrobe,
  input logic            tailWrStrobe,
  input logic            pendingQ,
  input logic            overflowQ,
  input logic [OffW-1:0] tailOff
);
  localparam logic [OffW-1:0] Step = OffW'(32);

  p_tail_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    pushStrobe && !tailWrStrobe |=> tailOff == $past(tailOff) + Step);

  p_disabled_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !queueEn && !tailWrStrobe |=> $stable(tailOff));

  p_pending_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    pushStrobe |=> pendingQ);

  p_full_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && queueEn && ringFull && !tailWrStrobe |=> overflowQ && $stable(tailOff));

  p_ovf_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    overflowQ && !tailWrStrobe |=> $stable(tailOff));

  p_ovf_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overflowQ) |-> $past(ringEmpty));
endmodule

bind prq_ring_queue prq_checker #(.OffW(OffW)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .queueEn(queueEn),
  .ringFull(ringFull), .ringEmpty(ringEmpty), .pushStrobe(pushStrobe),
  .tailWrStrobe(tailWrStrobe), .pendingQ(pendingQ), .overflowQ(overflowQ),
  .tailOff(tailOff)
);

// File: tb/prq_ring_queue_test.sv
module prq_ring_queue_test;
  localparam int ClkPeriod = 10;
  localparam int DEPTH = 4;
  localparam int IdxW = 2;
  localparam int Step = 32;
  localparam int Mask = DEPTH * 32 - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [255:0] reqData = '0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [IdxW-1:0] rdEntryIdx = '0;
  logic [255:0] rdEntryData;
  logic irqReq;

  prq_ring_queue #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqData(reqData),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .rdEntryIdx(rdEntryIdx),
    .rdEntryData(rdEntryData), .irqReq(irqReq)
  );

  always #(ClkPeriod / 2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [255:0] expQ [$];
  int mHead = 0, mTail = 0;
  bit mOvf = 0, mPend = 0, mEn = 0, mIrqEn = 0;

  task automatic check(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] mkDesc(int n);
    return {4{32'hC0DE0000 + 32'(n), 32'(n * 7 + 3)}};
  endfunction

  task automatic regWrite(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  // driver: predicts acceptance and queues the expected descriptor
  task automatic sendReq(logic [255:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqData = d;
    if (mEn && !mOvf) begin
      if (((mTail + Step) & Mask) != mHead) begin
        expQ.push_back(d);
        mTail = (mTail + Step) & Mask;
        mPend = 1;
      end else mOvf = 1;
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic writeStatus(logic [1:0] bits);
    regWrite(2'd2, {30'd0, bits});
    if (bits[0]) mPend = 0;
    if (bits[1] && mHead == mTail) mOvf = 0;
  endtask

  task automatic checkStatus(string req);
    logic [31:0] r;
    regRead(2'd2, r);
    check(req, r, {30'd0, mOvf, mPend});
  endtask

  // monitor: walks head to tail, pops and compares, then releases entries
  task automatic drain(string req);
    logic [31:0] r;
    int h;
    regRead(2'd1, r);
    check({req, " tail"}, r, 32'(mTail));
    h = mHead;
    while (h != mTail) begin
      rdEntryIdx = IdxW'(h / Step);
      #1;
      if (expQ.size() == 0) check({req, " queue"}, 1, 0);
      else check({req, " entry"}, rdEntryData, expQ.pop_front());
      h = (h + Step) & Mask;
    end
    regWrite(2'd0, 32'(mTail));
    mHead = mTail;
    regRead(2'd0, r);
    check("R8 head after release", r, 32'(mHead));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 / R10: reset values at every address
    for (int a = 0; a < 4; a++) begin
      regRead(2'(a), r);
      check("R1 R10 reset reg", r, 0);
    end
    check("R1 irq reset", irqReq, 0);

    // R3: disabled queue ignores requests
    sendReq(mkDesc(99));
    regRead(2'd1, r);
    check("R3 tail unchanged", r, 0);
    checkStatus("R3 status unchanged");

    // enable queue, interrupts off
    regWrite(2'd3, 32'd1); mEn = 1;
    sendReq(mkDesc(1));
    sendReq(mkDesc(2));
    regRead(2'd1, r);
    check("R2 tail advance", r, 64);
    checkStatus("R4 pending set");
    check("R9 irq masked", irqReq, 0);
    regWrite(2'd3, 32'd3); mIrqEn = 1;
    #1 check("R9 irq enabled", irqReq, 1);
    regRead(2'd3, r);
    check("R10 ctrl readback", r, 3);
    drain("R2 first batch");

    // R4 / R9: write-1-to-clear pending
    writeStatus(2'b01);
    checkStatus("R4 pending cleared");
    check("R9 irq drops", irqReq, 0);

    // R2 wrap and R5 full
    sendReq(mkDesc(3));
    sendReq(mkDesc(4));
    sendReq(mkDesc(5));
    regRead(2'd1, r);
    check("R2 tail wrapped", r, 32);
    sendReq(mkDesc(6));
    regRead(2'd1, r);
    check("R5 tail held when full", r, 32);
    checkStatus("R5 overflow set");
    sendReq(mkDesc(7));

    // R7: clear refused while entries remain
    writeStatus(2'b10);
    checkStatus("R7 overflow kept nonempty");
    drain("R5 R6 entries");
    // R6: blocked although there is room
    sendReq(mkDesc(8));
    regRead(2'd1, r);
    check("R6 tail held under overflow", r, 32);
    writeStatus(2'b10);
    checkStatus("R7 overflow cleared empty");
    sendReq(mkDesc(9));

    // R8: head write masked and aligned
    regWrite(2'd0, 32'h0000_0127);
    regRead(2'd0, r);
    check("R8 head masked", r, 32);
    drain("R2 after overflow");

    // R4: arrival wins over same-cycle clear
    @(negedge clk);
    reqValid = 1'b1; reqData = mkDesc(10);
    regWrEn = 1'b1; regAddr = 2'd2; regWrData = 32'd1;
    expQ.push_back(mkDesc(10)); mTail = (mTail + Step) & Mask; mPend = 1;
    @(negedge clk);
    reqValid = 1'b0; regWrEn = 1'b0;
    checkStatus("R4 set wins over clear");
    check("R9 irq on", irqReq, 1);
    drain("R2 final");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule